// File: doc/BRIEF.md
# Floppy Controller Low-Power Wake Gate

This block stands between the host bus and the register file of a floppy disk controller. It decides, access by access, whether the controller has to leave its low-power state. It decodes an eight-register window on an 8-bit host address and returns read data for that window. It also keeps a sleep flag that gates the drive-side interface.

The window holds the following registers:
- Two read-only status bytes, present only in the PS/2-style map.
- An output control register, written and read back.
- A shared offset that reads main status and writes rate select.
- The data port.
- A shared offset that reads the drive input byte and writes the configuration byte.

Only two things bring the controller out of sleep. The first is any touch of the data port. The second is a write to the output or rate register that either turns a motor on or requests a reset. Every other access is served while the controller stays asleep. Values written during sleep are held in shadow registers, and they reach the controller-facing outputs one clock after the wake.

Top module: `fdc_wake_gate`

## Requirements
- R1: Only addresses whose bits 7:3 equal bits 7:3 of `BASE` are decoded. Any other address reads as 8'hFF, and neither reads nor writes to it change any state.
- R2: Reads are mapped by offset (address bits 2:0) as follows:
  - 2: the stored output control byte.
  - 4: `msr_in`.
  - 5: `fifo_rdata`.
  - 7: `dir_in`.
  - 0 and 1: `sra_in` and `srb_in` when `ps2_mode`=1, and 8'hFF when `ps2_mode`=0.
  - 3 and 6: always 8'hFF.
- R3: A read or write at offset 5 asserts `fifo_rd` or `fifo_wr` combinationally. When asleep, it also wakes the block at the next clock edge.
- R4: A write at offset 2 wakes a sleeping block exactly when bits 7:4 (motor enables) are not all zero or bit 2 (active-low reset) is 0.
- R5: A write at offset 4 wakes a sleeping block exactly when bit 7 (software reset) is 1.
- R6: A write at offset 4 with bit 6 = 1 and bit 7 = 0 enters sleep at the next edge. If bit 7 is also 1, the block does not sleep.
- R7: `wake_pulse` is high for exactly one clock, in the cycle after a waking access made while asleep. In that same cycle `asleep` is already 0. Waking-type accesses made while awake give no pulse.
- R8: While asleep, reads of offsets 0–4, 6 and 7 return live status and leave the block asleep. So do non-waking writes.
- R9: Writes are stored in shadow registers: offset 2 keeps all 8 bits, offset 4 keeps bits 5:0 (bits 7:6 stored as 0), and offset 7 keeps bits 1:0. The applied outputs `dor_q`, `dsr_q` and `ccr_q` copy the shadows on every edge where the block was awake, and hold still while it sleeps.
- R10: `drive_en` is 0 while asleep and 1 while awake.
- R11: After reset the block is awake, `wake_pulse` is 0, and all stored and applied registers are 0.
- R12: Writes at offsets 0 and 1 are ignored in both maps. They change no stored register and do not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_mode | input | 1 | 1 selects the map with status bytes at offsets 0 and 1 |
| host_addr | input | 8 | Host address |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the decoded window |
| sra_in | input | 8 | Live status byte A |
| srb_in | input | 8 | Live status byte B |
| msr_in | input | 8 | Live main status byte |
| dir_in | input | 8 | Live drive input byte |
| fifo_rdata | input | 8 | Data port read value |
| fifo_rd | output | 1 | Data port read strobe |
| fifo_wr | output | 1 | Data port write strobe |
| asleep | output | 1 | Low-power flag |
| wake_pulse | output | 1 | One-clock wake indication |
| drive_en | output | 1 | Enable for the drive-side interface |
| dor_q | output | 8 | Applied output control byte |
| dsr_q | output | 8 | Applied rate select byte |
| ccr_q | output | 8 | Applied configuration byte |

## Verification
The bench builds the block with `BASE` = 8'h10, so that addresses just below and just above the window are legal and easy to aim at. At that base it sweeps all 256 byte values into the output and rate registers while the block is asleep. For each value it compares the wake outcome, the pulse and the held or applied output against a rule computed in the bench. Every offset is read in both maps, both asleep and awake. Out-of-window and read-only writes are then checked for having no effect at the ports.

// File: rtl/fdc_wake_pkg.sv
// Shared offsets, bit positions and select type for the wake gate.
// Assumes an eight-register window aligned on an eight-byte boundary.
package fdc_wake_pkg;

    localparam int OFS_W          = 3;
    localparam int MOTORS         = 4;
    localparam int DOUT_NRST_BIT  = 2;
    localparam int DOUT_MOTOR_LSB = 4;
    localparam int RATE_SWRST_BIT = 7;
    localparam int RATE_PDOWN_BIT = 6;

    typedef enum logic [OFS_W-1:0] {
        OFS_STAT_A    = 3'd0,
        OFS_STAT_B    = 3'd1,
        OFS_OUT_CTL   = 3'd2,
        OFS_GAP3      = 3'd3,
        OFS_STAT_RATE = 3'd4,
        OFS_DATA      = 3'd5,
        OFS_GAP6      = 3'd6,
        OFS_DIN_CFG   = 3'd7
    } ofs_e;

    typedef struct packed {
        logic stat_a;
        logic stat_b;
        logic out_ctl;
        logic stat_rate;
        logic data;
        logic din_cfg;
    } sel_t;

endpackage

// File: rtl/fdc_addr_decode.sv
// Address decoder: flags a hit on the eight-byte window at BASE and gives
// one select per implemented register. The status-byte selects exist only
// in the PS/2-style map. Purely combinational.
module fdc_addr_decode
    import fdc_wake_pkg::*;
#(
    parameter int               ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE  = 8'hF0
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              ps2_mode,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs,
    output sel_t              sel
);

    localparam int HI_W = ADDR_W - OFS_W;

    // Window compare and per-register selects.
    always_comb begin
        hit           = (host_addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
        ofs           = host_addr[OFS_W-1:0];
        sel.stat_a    = hit && ps2_mode && (ofs == OFS_STAT_A);
        sel.stat_b    = hit && ps2_mode && (ofs == OFS_STAT_B);
        sel.out_ctl   = hit && (ofs == OFS_OUT_CTL);
        sel.stat_rate = hit && (ofs == OFS_STAT_RATE);
        sel.data      = hit && (ofs == OFS_DATA);
        sel.din_cfg   = hit && (ofs == OFS_DIN_CFG);
    end

    if (HI_W < 1) begin : g_bad_width
        initial $error("ADDR_W must exceed OFS_W");
    end

endmodule

// File: rtl/fdc_wake_ctrl.sv
// Sleep/wake controller. Decides from register select and written bits
// whether an access wakes the controller, enters sleep on a powerdown
// request, and pulses wake_pulse for one clock on each exit from sleep.
// Assumes strobes last one cycle per access.
module fdc_wake_ctrl
    import fdc_wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sel_t              sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [MOTORS-1:0] motor_bits,
    input  logic              nrst_bit,
    input  logic              swrst_bit,
    input  logic              pdown_bit,
    output logic              asleep,
    output logic              wake_pulse
);

    logic wake_req;
    logic sleep_req;

    // Wake and sleep request terms.
    always_comb begin
        wake_req  = ((host_rd || host_wr) && sel.data)
                 || (host_wr && sel.out_ctl && ((|motor_bits) || !nrst_bit))
                 || (host_wr && sel.stat_rate && swrst_bit);
        sleep_req = host_wr && sel.stat_rate && pdown_bit && !swrst_bit;
    end

    // Sleep flag and one-clock wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep     <= 1'b0;
            wake_pulse <= 1'b0;
        end else begin
            wake_pulse <= asleep && wake_req;
            if (wake_req)       asleep <= 1'b0;
            else if (sleep_req) asleep <= 1'b1;
        end
    end

endmodule

// File: rtl/fdc_retain_reg.sv
// Retained register: a shadow that takes every write (masked to its
// implemented bits) and an applied copy that follows the shadow only on
// edges where the controller was awake.
module fdc_retain_reg #(
    parameter int           W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         asleep,
    output logic [W-1:0] shadow_q,
    output logic [W-1:0] live_q
);

    // Shadow capture of host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= '0;
        else if (wr_en) shadow_q <= wdata & MASK;
    end

    // Applied copy, frozen during sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)       live_q <= '0;
        else if (!asleep) live_q <= shadow_q;
    end

endmodule

// File: rtl/fdc_wake_gate.sv
// Top of the low-power wake gate. Decodes the host window, serves reads,
// retains writes made during sleep, and drives the wake/sleep outputs and
// the drive-side enable. Assumes single-cycle strobes, never both at once.
module fdc_wake_gate
    import fdc_wake_pkg::*;
#(
    parameter logic [7:0] BASE = 8'hF0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_mode,
    input  logic [7:0] host_addr,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic [7:0] sra_in,
    input  logic [7:0] srb_in,
    input  logic [7:0] msr_in,
    input  logic [7:0] dir_in,
    input  logic [7:0] fifo_rdata,
    output logic       fifo_rd,
    output logic       fifo_wr,
    output logic       asleep,
    output logic       wake_pulse,
    output logic       drive_en,
    output logic [7:0] dor_q,
    output logic [7:0] dsr_q,
    output logic [7:0] ccr_q
);

    localparam int         DW        = 8;
    localparam logic [7:0] RATE_MASK = 8'h3F;
    localparam logic [7:0] CFG_MASK  = 8'h03;

    logic             hit;
    logic [OFS_W-1:0] ofs;
    sel_t             sel;
    logic [DW-1:0]    dor_shadow;
    logic [DW-1:0]    dsr_shadow;
    logic [DW-1:0]    ccr_shadow;

    fdc_addr_decode #(.ADDR_W(DW), .BASE(BASE)) u_dec (
        .host_addr (host_addr),
        .ps2_mode  (ps2_mode),
        .hit       (hit),
        .ofs       (ofs),
        .sel       (sel)
    );

    fdc_wake_ctrl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .motor_bits (host_wdata[DOUT_MOTOR_LSB +: MOTORS]),
        .nrst_bit   (host_wdata[DOUT_NRST_BIT]),
        .swrst_bit  (host_wdata[RATE_SWRST_BIT]),
        .pdown_bit  (host_wdata[RATE_PDOWN_BIT]),
        .asleep     (asleep),
        .wake_pulse (wake_pulse)
    );

    fdc_retain_reg #(.W(DW), .MASK('1)) u_dor (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr && sel.out_ctl),
        .wdata    (host_wdata),
        .asleep   (asleep),
        .shadow_q (dor_shadow),
        .live_q   (dor_q)
    );

    fdc_retain_reg #(.W(DW), .MASK(RATE_MASK)) u_dsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr && sel.stat_rate),
        .wdata    (host_wdata),
        .asleep   (asleep),
        .shadow_q (dsr_shadow),
        .live_q   (dsr_q)
    );

    fdc_retain_reg #(.W(DW), .MASK(CFG_MASK)) u_ccr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr && sel.din_cfg),
        .wdata    (host_wdata),
        .asleep   (asleep),
        .shadow_q (ccr_shadow),
        .live_q   (ccr_q)
    );

    // Read data mux over the decoded window.
    always_comb begin
        host_rdata = '1;
        if (hit) begin
            case (ofs_e'(ofs))
                OFS_STAT_A:    host_rdata = sel.stat_a ? sra_in : '1;
                OFS_STAT_B:    host_rdata = sel.stat_b ? srb_in : '1;
                OFS_OUT_CTL:   host_rdata = dor_shadow;
                OFS_STAT_RATE: host_rdata = msr_in;
                OFS_DATA:      host_rdata = fifo_rdata;
                OFS_DIN_CFG:   host_rdata = dir_in;
                default:       host_rdata = '1;
            endcase
        end
    end

    // Data port strobes and drive-side enable.
    always_comb begin
        fifo_rd  = host_rd && sel.data;
        fifo_wr  = host_wr && sel.data;
        drive_en = !asleep;
    end

    logic unused_ok;
    assign unused_ok = ^{dsr_shadow, ccr_shadow};

endmodule

// File: rtl/fdc_wake_gate_chk.sv
// Property checker for fdc_wake_gate, attached by bind below.
module fdc_wake_gate_chk #(
    parameter logic [7:0] BASE = 8'hF0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ps2_mode,
    input logic [7:0] host_addr,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       asleep,
    input logic       wake_pulse,
    input logic [7:0] dor_q
);

    localparam logic [7:0] A_RATE = BASE + 8'd4;
    localparam logic [7:0] A_DATA = BASE + 8'd5;

    // R3
    data_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && (host_rd || host_wr) && host_addr == A_DATA) |=> (!asleep && wake_pulse));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R7
    pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(asleep));

    // R6
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(host_wr && host_addr == A_RATE && host_wdata[6] && !host_wdata[7]));

    // R9
    frozen_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(asleep) |-> $stable(dor_q));

    // R2
    at_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps2_mode && host_addr == BASE) |-> host_rdata == 8'hFF);

    // R8
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && host_rd && !host_wr && host_addr == A_RATE) |=> asleep);

endmodule

bind fdc_wake_gate fdc_wake_gate_chk #(.BASE(BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ps2_mode   (ps2_mode),
    .host_addr  (host_addr),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .asleep     (asleep),
    .wake_pulse (wake_pulse),
    .dor_q      (dor_q)
);

// File: tb/fdc_wake_gate_test.sv
module fdc_wake_gate_test;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] B          = 8'h10;
    localparam logic [7:0] V_SRA = 8'hA1, V_SRB = 8'hB2, V_MSR = 8'hC3;
    localparam logic [7:0] V_DIR = 8'hD4, V_FIFO = 8'hE5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_mode = 1'b1;
    logic [7:0] host_addr = '0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       fifo_rd, fifo_wr, asleep, wake_pulse, drive_en;
    logic [7:0] dor_q, dsr_q, ccr_q;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] rd_seen;
    logic       frd_seen, fwr_seen;

    fdc_wake_gate #(.BASE(B)) uut (
        .clk(clk), .rst_n(rst_n), .ps2_mode(ps2_mode), .host_addr(host_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .sra_in(V_SRA), .srb_in(V_SRB), .msr_in(V_MSR),
        .dir_in(V_DIR), .fifo_rdata(V_FIFO), .fifo_rd(fifo_rd), .fifo_wr(fifo_wr),
        .asleep(asleep), .wake_pulse(wake_pulse), .drive_en(drive_en),
        .dor_q(dor_q), .dsr_q(dsr_q), .ccr_q(ccr_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: strobes held for one cycle, combinational outputs sampled mid-cycle.
    task automatic acc(input logic [7:0] a, input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = r; host_wr = w; host_wdata = d;
        #1;
        rd_seen = host_rdata; frd_seen = fifo_rd; fwr_seen = fifo_wr;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
    endtask

    function automatic logic rule_dor_wakes(input logic [7:0] v);
        return (v[7:4] != 4'd0) || (v[2] == 1'b0);
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] o, input logic ps2, input logic [7:0] dor);
        case (o)
            3'd0: return ps2 ? V_SRA : 8'hFF;
            3'd1: return ps2 ? V_SRB : 8'hFF;
            3'd2: return dor;
            3'd4: return V_MSR;
            3'd5: return V_FIFO;
            3'd7: return V_DIR;
            default: return 8'hFF;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        logic [7:0] held;
        logic       w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 asleep", {7'd0, asleep}, 8'd0);
        chk("R11 pulse", {7'd0, wake_pulse}, 8'd0);
        chk("R11 dor", dor_q, 8'd0);
        chk("R11 dsr", dsr_q, 8'd0);
        chk("R11 ccr", ccr_q, 8'd0);
        chk("R10 drive_en awake", {7'd0, drive_en}, 8'd1);

        // R2 read map in both maps, awake
        for (int m = 0; m < 2; m++) begin
            ps2_mode = m[0];
            for (int o = 0; o < 8; o++) begin
                acc(B + 8'(o), 1'b1, 1'b0, 8'h00);
                chk("R2 read map", rd_seen, exp_read(3'(o), m[0], 8'h00));
                chk("R3 fifo_rd", {7'd0, frd_seen}, {7'd0, (o == 5)});
            end
        end
        ps2_mode = 1'b1;

        // R1 outside window
        acc(B - 8'd1, 1'b1, 1'b0, 8'h00);
        chk("R1 below window read", rd_seen, 8'hFF);
        acc(B + 8'd8, 1'b1, 1'b0, 8'h00);
        chk("R1 above window read", rd_seen, 8'hFF);
        acc(B + 8'd10, 1'b0, 1'b1, 8'h5A);
        @(negedge clk);
        chk("R1 stray write dor", dor_q, 8'h00);

        // R6 reset bit overrides powerdown
        acc(B + 8'd4, 1'b0, 1'b1, 8'hC0);
        chk("R6 no sleep with reset bit", {7'd0, asleep}, 8'd0);
        chk("R7 no pulse while awake", {7'd0, wake_pulse}, 8'd0);

        // R4 sweep of output control writes while asleep
        for (int v = 0; v < 256; v++) begin
            acc(B + 8'd4, 1'b0, 1'b1, 8'h40);
            chk("R6 sleep entry", {7'd0, asleep}, 8'd1);
            chk("R10 drive_en asleep", {7'd0, drive_en}, 8'd0);
            held = dor_q;
            w = rule_dor_wakes(8'(v));
            acc(B + 8'd2, 1'b0, 1'b1, 8'(v));
            chk("R4 wake decision", {7'd0, asleep}, {7'd0, !w});
            chk("R7 pulse", {7'd0, wake_pulse}, {7'd0, w});
            if (!w) begin
                @(negedge clk);
                chk("R9 held while asleep", dor_q, held);
                acc(B + 8'd2, 1'b1, 1'b0, 8'h00);
                chk("R8 readback asleep", rd_seen, 8'(v));
                chk("R8 still asleep", {7'd0, asleep}, 8'd1);
                acc(B + 8'd5, 1'b1, 1'b0, 8'h00);
                chk("R3 data read wakes", {7'd0, asleep}, 8'd0);
                chk("R7 pulse on data wake", {7'd0, wake_pulse}, 8'd1);
            end
            @(negedge clk);
            chk("R7 one clock", {7'd0, wake_pulse}, 8'd0);
            chk("R9 applied after wake", dor_q, 8'(v));
        end

        // R5 sweep of rate writes while asleep
        for (int v = 0; v < 256; v++) begin
            acc(B + 8'd4, 1'b0, 1'b1, 8'h40);
            w = v[7];
            acc(B + 8'd4, 1'b0, 1'b1, 8'(v));
            chk("R5 wake decision", {7'd0, asleep}, {7'd0, !w});
            chk("R7 pulse", {7'd0, wake_pulse}, {7'd0, w});
            if (!w) begin
                acc(B + 8'd5, 1'b0, 1'b1, 8'h00);
                chk("R3 fifo_wr", {7'd0, fwr_seen}, 8'd1);
                chk("R3 data write wakes", {7'd0, asleep}, 8'd0);
            end
            @(negedge clk);
            chk("R9 rate masked", dsr_q, 8'(v) & 8'h3F);
        end

        // R8 every status read while asleep, both maps
        acc(B + 8'd2, 1'b0, 1'b1, 8'h0C);
        for (int m = 0; m < 2; m++) begin
            ps2_mode = m[0];
            acc(B + 8'd4, 1'b0, 1'b1, 8'h40);
            for (int o = 0; o < 8; o++) begin
                if (o != 5) begin
                    acc(B + 8'(o), 1'b1, 1'b0, 8'h00);
                    chk("R8 asleep read", rd_seen, exp_read(3'(o), m[0], 8'h0C));
                    chk("R8 stays asleep", {7'd0, asleep}, 8'd1);
                end
            end
            acc(B + 8'd5, 1'b1, 1'b0, 8'h00);
        end
        ps2_mode = 1'b1;

        // R9 configuration retained during sleep
        acc(B + 8'd4, 1'b0, 1'b1, 8'h40);
        acc(B + 8'd7, 1'b0, 1'b1, 8'hFE);
        @(negedge clk);
        chk("R9 cfg held", ccr_q, 8'h00);
        chk("R8 cfg write no wake", {7'd0, asleep}, 8'd1);

        // R12 writes at offsets 0 and 1 ignored
        for (int m = 0; m < 2; m++) begin
            ps2_mode = m[0];
            acc(B, 1'b0, 1'b1, 8'hF0);
            acc(B + 8'd1, 1'b0, 1'b1, 8'h80);
            chk("R12 no wake", {7'd0, asleep}, 8'd1);
            acc(B + 8'd2, 1'b1, 1'b0, 8'h00);
            chk("R12 dor unchanged", rd_seen, 8'h0C);
        end
        ps2_mode = 1'b1;
        acc(B + 8'd5, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        chk("R9 cfg applied", ccr_q, 8'h02);
        chk("R12 dor applied", dor_q, 8'h0C);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule